// File: doc/BRIEF.md
# Windowed Watchdog Supervisor

This block supervises host software through a watchdog that is refreshed by decoded serial writes. When reset is released it starts a fixed initialisation timeout. During that timeout the host must write the unlock word 0x5A00 over the serial path. That write moves the supervisor into normal operation. From then on, each refresh strobe is checked against one of four selectable periods. In window style, a refresh must fall in the second half of the period. In plain-timeout style, a refresh may arrive at any point before the period ends.

Any failure sets a sticky flag that stays set until software reads it, and drives a reset request for a fixed number of clock cycles. After the reset pulse the supervisor returns to initialisation. A debug input removes all timing constraints. An optional interrupt guard checks that the host acknowledges a raised interrupt within two watchdog periods.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rst_req_o` and `wd_fail_o` are 0 and the block is in initialisation with its cycle count at 0.
- R2: In initialisation, a refresh strobe with `refresh_word_i` equal to 16'h5A00 enters normal operation with the count at 0. A refresh with any other word is ignored: it neither fails nor restarts the count.
- R3: If no unlock word arrives before the initialisation count reaches INIT_CYC-1, the next clock edge is a failure.
- R4: In normal operation the count gives the cycles since the period began. With `win_mode_i`=1, a refresh is accepted when the count is at least P/2 and at most P-1, and the count then restarts at 0.
- R5: With `win_mode_i`=1, a refresh while the count is below P/2 is a failure.
- R6: With `win_mode_i`=0, a refresh at any count is accepted and restarts the period.
- R7: If the count reaches P-1 with no refresh in that cycle, the edge is a failure.
- R8: `per_sel_i` values 0, 1, 2 and 3 select period P = PER0, PER1, PER2 and PER3 cycles.
- R9: A failure drives `rst_req_o` high for exactly RST_CYC cycles, starting in the cycle after the failing edge. The block then re-enters initialisation with the count at 0.
- R10: `wd_fail_o` goes to 1 in the cycle after a failure and holds. A `flag_rd_i` strobe clears it in the following cycle, unless a failure occurs at the same edge, in which case the flag stays set.
- R11: While `debug_i` is 1, no failure is raised. A count that reaches its limit wraps to 0, and a refresh in the closed half restarts the period.
- R12: With `irq_chk_en_i`=1 in normal operation, `irq_i` arms a guard that `irq_ack_i` clears. If the guard has been armed for 2P edges without an acknowledge, that edge is a failure. With `irq_chk_en_i`=0, `irq_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refresh_i | input | 1 | Decoded serial write strobe to the watchdog register |
| refresh_word_i | input | 16 | Full 16-bit serial word carried with the strobe |
| win_mode_i | input | 1 | 1: window refresh, 0: plain timeout |
| per_sel_i | input | 2 | Period select |
| irq_chk_en_i | input | 1 | Enables the interrupt-service guard |
| irq_i | input | 1 | Interrupt raised towards the host (strobe) |
| irq_ack_i | input | 1 | Host read of the interrupt register (strobe) |
| debug_i | input | 1 | Debug mode, suppresses failures |
| flag_rd_i | input | 1 | Serial read of the failure flag (strobe) |
| rst_req_o | output | 1 | Reset request pulse |
| wd_fail_o | output | 1 | Sticky watchdog failure flag |

## Verification
The bench aims at refreshes landing exactly on P/2-1 and P/2. A design with an off-by-one window edge would either reset the host on a legal refresh or let an early one through. It also checks timeouts at the last count of the initialisation phase and of each period. A count that is one cycle too long or too short shows up as a reset pulse arriving in the wrong cycle. Further cases are a read of the flag coinciding with a new failure (the flag must not be lost), wrong unlock words (they must not start normal operation), debug mode (no pulse may appear), and an acknowledge that is one cycle late against the two-period interrupt deadline.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WD_INIT = 2'd0,
    WD_RUN  = 2'd1,
    WD_HOLD = 2'd2
  } wd_state_e;

  localparam logic [15:0] WD_UNLOCK = 16'h5A00;

  // refresh in the closed first half of a period
  function automatic logic wd_is_early(input int unsigned cnt, input int unsigned per);
    return cnt < (per >> 1);
  endfunction

  // last count of the two-period interrupt deadline
  function automatic int unsigned wd_irq_last(input int unsigned per);
    return (per << 1) - 1;
  endfunction

endpackage

// File: rtl/wdog_period_sel.sv
module wdog_period_sel #(
  parameter int CW   = 16,
  parameter int PER0 = 64,
  parameter int PER1 = 128,
  parameter int PER2 = 192,
  parameter int PER3 = 256
) (
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] period_o
);
  localparam int NSEL = 4;
  localparam int PERS [NSEL] = '{PER0, PER1, PER2, PER3};

  logic [CW-1:0] tbl [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_tbl
    assign tbl[g] = CW'(PERS[g]);
  end

  assign period_o = tbl[sel_i];
endmodule

// File: rtl/wdog_irq_guard.sv
module wdog_irq_guard #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          arm_ok_i,
  input  logic          irq_i,
  input  logic          ack_i,
  input  logic          debug_i,
  input  logic [CW-1:0] period_i,
  output logic          late_o
);
  import wdog_pkg::*;

  logic          pend;
  logic [CW:0]   pcnt;
  logic [CW:0]   lim;

  assign lim    = (CW+1)'(wd_irq_last(32'(period_i)));
  assign late_o = pend && en_i && (pcnt >= lim) && !ack_i && !debug_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      pcnt <= '0;
    end else if (!arm_ok_i || ack_i || !en_i) begin
      pend <= 1'b0;
      pcnt <= '0;
    end else if (pend) begin
      if (pcnt < lim) pcnt <= pcnt + 1'b1;
    end else if (irq_i) begin
      pend <= 1'b1;
      pcnt <= '0;
    end
  end
endmodule

// File: rtl/wdog_fail_flag.sv
module wdog_fail_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (rd_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int CW       = 16,
  parameter int INIT_CYC = 512,
  parameter int RST_CYC  = 4,
  parameter int PER0     = 64,
  parameter int PER1     = 128,
  parameter int PER2     = 192,
  parameter int PER3     = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        refresh_i,
  input  logic [15:0] refresh_word_i,
  input  logic        win_mode_i,
  input  logic [1:0]  per_sel_i,
  input  logic        irq_chk_en_i,
  input  logic        irq_i,
  input  logic        irq_ack_i,
  input  logic        debug_i,
  input  logic        flag_rd_i,
  output logic        rst_req_o,
  output logic        wd_fail_o
);
  import wdog_pkg::*;

  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);

  wd_state_e     st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] period;
  logic [CW-1:0] per_last;

  // named internal events
  logic in_init, in_run, key_ok;
  logic init_expired, early_refresh, missed_refresh, irq_late, fail_evt;

  wdog_period_sel #(
    .CW(CW), .PER0(PER0), .PER1(PER1), .PER2(PER2), .PER3(PER3)
  ) u_per (
    .sel_i    (per_sel_i),
    .period_o (period)
  );

  assign per_last       = period - CW'(1);
  assign in_init        = (st == WD_INIT);
  assign in_run         = (st == WD_RUN);
  assign key_ok         = refresh_i && (refresh_word_i == WD_UNLOCK);
  assign init_expired   = in_init && !key_ok && (cnt >= INIT_LAST);
  assign early_refresh  = in_run && refresh_i && win_mode_i && wd_is_early(32'(cnt), 32'(period));
  assign missed_refresh = in_run && !refresh_i && (cnt >= per_last);
  assign fail_evt       = !debug_i && (init_expired || early_refresh || missed_refresh || irq_late);

  wdog_irq_guard #(.CW(CW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (irq_chk_en_i),
    .arm_ok_i (in_run && !fail_evt),
    .irq_i    (irq_i),
    .ack_i    (irq_ack_i),
    .debug_i  (debug_i),
    .period_i (period),
    .late_o   (irq_late)
  );

  wdog_fail_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (fail_evt),
    .rd_i   (flag_rd_i),
    .flag_o (wd_fail_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= WD_INIT;
      cnt <= '0;
    end else if (fail_evt) begin
      st  <= WD_HOLD;
      cnt <= '0;
    end else begin
      unique case (st)
        WD_HOLD: begin
          if (cnt >= RST_LAST) begin
            st  <= WD_INIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WD_INIT: begin
          if (key_ok) begin
            st  <= WD_RUN;
            cnt <= '0;
          end else if (cnt >= INIT_LAST) begin
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WD_RUN: begin
          if (refresh_i || cnt >= per_last) cnt <= '0;
          else                              cnt <= cnt + 1'b1;
        end
        default: begin
          st  <= WD_INIT;
          cnt <= '0;
        end
      endcase
    end
  end

  assign rst_req_o = (st == WD_HOLD);

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int RST_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       debug_i,
  input logic       flag_rd_i,
  input logic       rst_req_o,
  input logic       wd_fail_o,
  input logic       fail_evt,
  input logic       early_refresh,
  input logic       key_ok,
  input logic [1:0] st
);
  logic [31:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= '0;
    else if (rst_req_o) hi_len <= hi_len + 1;
    else                hi_len <= '0;
  end

  // R9: failure drives the reset request and the flag in the next cycle
  p_fail_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (rst_req_o && wd_fail_o));

  // R9: each reset pulse lasts exactly RST_CYC cycles
  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> (hi_len == 32'(RST_CYC)));

  // R5: a closed-window refresh outside debug triggers the reset request
  p_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (early_refresh && !debug_i) |=> rst_req_o);

  // R11: debug mode never starts a reset pulse
  p_debug_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    debug_i |=> !$rose(rst_req_o));

  // R10: a read with no concurrent failure clears the flag
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_i && !fail_evt) |=> !wd_fail_o);

  // R2: the unlock word moves initialisation into normal operation
  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 2'd0) && key_ok) |=> (st == 2'd1));

endmodule

bind wdog_supervisor wdog_supervisor_chk #(.RST_CYC(RST_CYC)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .debug_i       (debug_i),
  .flag_rd_i     (flag_rd_i),
  .rst_req_o     (rst_req_o),
  .wd_fail_o     (wd_fail_o),
  .fail_evt      (fail_evt),
  .early_refresh (early_refresh),
  .key_ok        (key_ok),
  .st            (st)
);

// File: tb/wdog_supervisor_tb.sv
`timescale 1ns/100ps
module wdog_supervisor_tb_top;
  localparam int INIT_CYC = 64;
  localparam int RST_CYC  = 3;
  localparam int P0 = 16, P1 = 24, P2 = 32, P3 = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_ref = 1'b0;
  logic [15:0] b_word = 16'h0;
  logic        b_win = 1'b1;
  logic [1:0]  b_sel = 2'd0;
  logic        b_en = 1'b0, b_irq = 1'b0, b_ack = 1'b0, b_dbg = 1'b0, b_rd = 1'b0;
  logic        rst_req_o, wd_fail_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // bench reference state (0 init, 1 run, 2 hold)
  int m_st = 0, m_cnt = 0, m_pend = 0, m_pcnt = 0;
  bit m_flag = 0;

  always #2.5 clk = ~clk;

  wdog_supervisor #(
    .CW(16), .INIT_CYC(INIT_CYC), .RST_CYC(RST_CYC),
    .PER0(P0), .PER1(P1), .PER2(P2), .PER3(P3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .refresh_i(b_ref), .refresh_word_i(b_word),
    .win_mode_i(b_win), .per_sel_i(b_sel), .irq_chk_en_i(b_en), .irq_i(b_irq),
    .irq_ack_i(b_ack), .debug_i(b_dbg), .flag_rd_i(b_rd),
    .rst_req_o(rst_req_o), .wd_fail_o(wd_fail_o)
  );

  function automatic int exp_period(input logic [1:0] s);
    case (s)
      2'd0: return P0;
      2'd1: return P1;
      2'd2: return P2;
      default: return P3;
    endcase
  endfunction

  function automatic bit exp_closed(input int c, input int p);
    return (2 * c) < p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int p; bit key, fail, late, arm;
    int n_st, n_cnt;
    p    = exp_period(b_sel);
    key  = b_ref && (b_word == 16'h5A00);
    late = (m_pend != 0) && b_en && (m_pcnt >= 2 * p - 1) && !b_ack && !b_dbg;
    fail = 0;
    if (!b_dbg) begin
      if (m_st == 0 && !key && m_cnt >= INIT_CYC - 1) fail = 1;
      if (m_st == 1 && b_ref && b_win && exp_closed(m_cnt, p)) fail = 1;
      if (m_st == 1 && !b_ref && m_cnt >= p - 1) fail = 1;
      if (late) fail = 1;
    end
    arm = (m_st == 1) && !fail;
    if (!arm || b_ack || !b_en) begin
      m_pend = 0; m_pcnt = 0;
    end else if (m_pend != 0) begin
      if (m_pcnt < 2 * p - 1) m_pcnt++;
    end else if (b_irq) begin
      m_pend = 1; m_pcnt = 0;
    end
    n_st = m_st; n_cnt = m_cnt;
    if (fail) begin
      n_st = 2; n_cnt = 0;
    end else if (m_st == 2) begin
      if (m_cnt >= RST_CYC - 1) begin n_st = 0; n_cnt = 0; end
      else n_cnt = m_cnt + 1;
    end else if (m_st == 0) begin
      if (key) begin n_st = 1; n_cnt = 0; end
      else if (m_cnt >= INIT_CYC - 1) n_cnt = 0;
      else n_cnt = m_cnt + 1;
    end else begin
      if (b_ref || m_cnt >= p - 1) n_cnt = 0;
      else n_cnt = m_cnt + 1;
    end
    if (fail) m_flag = 1;
    else if (b_rd) m_flag = 0;
    m_st = n_st; m_cnt = n_cnt;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(rst_req_o == (m_st == 2), {cur_req, " rst_req"}, int'(rst_req_o), int'(m_st == 2));
    chk(wd_fail_o == m_flag, {cur_req, " flag"}, int'(wd_fail_o), int'(m_flag));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_ref(input logic [15:0] w);
    b_ref = 1'b1; b_word = w; tick(); b_ref = 1'b0; b_word = 16'h0;
  endtask

  task automatic unlock();
    pulse_ref(16'h5A00);
  endtask

  // wait until the reset pulse has ended (bench then sits in init at count 0)
  task automatic wait_hold_end();
    for (int i = 0; i < 20 && rst_req_o; i++) tick();
  endtask

  initial begin
    void'($urandom(32'd7311));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rst_req_o == 1'b0, "R1 rst_req in reset", int'(rst_req_o), 0);
    chk(wd_fail_o == 1'b0, "R1 flag in reset", int'(wd_fail_o), 0);
    rst_n = 1'b1;
    tick();
    chk(rst_req_o == 1'b0 && wd_fail_o == 1'b0, "R1 after release", int'({rst_req_o, wd_fail_o}), 0);

    // R2: wrong words are ignored in init, then unlock
    cur_req = "R2";
    for (int i = 0; i < 5; i++) pulse_ref(16'h1234 + 16'(i));
    pulse_ref(16'h5A01);
    chk(rst_req_o == 1'b0, "R2 wrong word ignored", int'(rst_req_o), 0);
    unlock();

    // R4 and R8: window edges for every period select
    cur_req = "R4";
    b_win = 1'b1;
    for (int s = 0; s < 4; s++) begin
      b_sel = 2'(s);
      cur_req = "R8";
      ticks(exp_period(2'(s)) / 2); pulse_ref(16'h0);      // count P/2
      ticks(exp_period(2'(s)) - 1); pulse_ref(16'h0);      // count P-1
      chk(rst_req_o == 1'b0, "R8 legal window edges", int'(rst_req_o), 0);
    end

    // R5 / R9 / R10: refresh one cycle before the window opens
    cur_req = "R5";
    b_sel = 2'd0;
    ticks(P0 / 2 - 1); pulse_ref(16'h0);
    chk(rst_req_o == 1'b1, "R5 early refresh fails", int'(rst_req_o), 1);
    chk(wd_fail_o == 1'b1, "R10 flag set", int'(wd_fail_o), 1);
    cur_req = "R9";
    begin
      int len = 1;
      while (len < 20) begin tick(); if (!rst_req_o) break; len++; end
      chk(len == RST_CYC, "R9 pulse length", len, RST_CYC);
    end
    cur_req = "R10";
    b_rd = 1'b1; tick(); b_rd = 1'b0;
    chk(wd_fail_o == 1'b0, "R10 flag cleared by read", int'(wd_fail_o), 0);

    // R3: initialisation timeout (block entered init at count 0 above, one read tick spent)
    cur_req = "R3";
    ticks(INIT_CYC - 2);
    chk(rst_req_o == 1'b0, "R3 before init limit", int'(rst_req_o), 0);
    tick();
    chk(rst_req_o == 1'b1, "R3 init timeout", int'(rst_req_o), 1);
    // R10: read at the same edge as a new failure keeps the flag
    wait_hold_end();
    ticks(INIT_CYC - 1);
    b_rd = 1'b1; cur_req = "R10"; tick(); b_rd = 1'b0;
    chk(wd_fail_o == 1'b1, "R10 set beats read", int'(wd_fail_o), 1);
    wait_hold_end();
    b_rd = 1'b1; tick(); b_rd = 1'b0;

    // R6: plain timeout accepts any refresh
    cur_req = "R6";
    unlock();
    b_win = 1'b0;
    pulse_ref(16'h0); pulse_ref(16'h0); tick(); pulse_ref(16'h0);
    chk(rst_req_o == 1'b0, "R6 early refresh accepted", int'(rst_req_o), 0);

    // R7: missed refresh
    cur_req = "R7";
    b_sel = 2'd1;
    ticks(P1 - 1);
    chk(rst_req_o == 1'b0, "R7 before period end", int'(rst_req_o), 0);
    tick();
    chk(rst_req_o == 1'b1, "R7 missed refresh", int'(rst_req_o), 1);
    wait_hold_end();
    b_rd = 1'b1; tick(); b_rd = 1'b0;

    // R11: debug suppresses every failure
    cur_req = "R11";
    b_dbg = 1'b1;
    ticks(INIT_CYC + 5);
    unlock();
    b_win = 1'b1;
    pulse_ref(16'h0);
    ticks(3 * P1);
    chk(rst_req_o == 1'b0 && wd_fail_o == 1'b0, "R11 debug quiet", int'({rst_req_o, wd_fail_o}), 0);
    b_dbg = 1'b0;
    pulse_ref(16'h0);   // restart period cleanly outside debug? closed half -> fail
    wait_hold_end();
    b_rd = 1'b1; tick(); b_rd = 1'b0;

    // R12: interrupt service guard
    cur_req = "R12";
    unlock();
    b_win = 1'b0; b_sel = 2'd0; b_en = 1'b1;
    b_ref = 1'b1;                      // keep refreshing every cycle
    b_irq = 1'b1; tick(); b_irq = 1'b0;
    ticks(20);
    b_ack = 1'b1; tick(); b_ack = 1'b0;
    ticks(2 * P0 + 4);
    chk(rst_req_o == 1'b0, "R12 acknowledged in time", int'(rst_req_o), 0);
    b_irq = 1'b1; tick(); b_irq = 1'b0;
    ticks(2 * P0 - 1);
    chk(rst_req_o == 1'b0, "R12 before deadline", int'(rst_req_o), 0);
    tick();
    chk(rst_req_o == 1'b1, "R12 late acknowledge", int'(rst_req_o), 1);
    b_ref = 1'b0;
    wait_hold_end();
    b_rd = 1'b1; tick(); b_rd = 1'b0;
    unlock();
    b_en = 1'b0; b_ref = 1'b1;
    b_irq = 1'b1; tick(); b_irq = 1'b0;
    ticks(3 * P0);
    chk(rst_req_o == 1'b0, "R12 guard disabled", int'(rst_req_o), 0);
    b_ref = 1'b0;

    // constrained random mix, checked cycle by cycle against the bench model
    cur_req = "R4 R7 R12 random";
    for (int i = 0; i < 6000; i++) begin
      if (i % 250 == 0) begin
        b_sel = 2'($urandom_range(0, 3));
        b_win = 1'($urandom_range(0, 1));
        b_dbg = ($urandom_range(0, 5) == 0);
        b_en  = 1'($urandom_range(0, 1));
      end
      b_ref  = ($urandom_range(0, 15) == 0);
      b_word = ($urandom_range(0, 3) == 0) ? 16'h5A00 : 16'($urandom);
      b_irq  = ($urandom_range(0, 60) == 0);
      b_ack  = ($urandom_range(0, 50) == 0);
      b_rd   = ($urandom_range(0, 30) == 0);
      tick();
    end
    b_ref = 0; b_irq = 0; b_ack = 0; b_rd = 0;

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule